// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block steers data hazards for a five-stage in-order integer pipeline. It looks at the register specifiers and a few control bits held in the pipeline registers between stages. From them it produces two selects for the operand multiplexers in front of the ALU, so that a result still travelling down the pipeline can be used before it is written back. When an instruction needs a value that a load in the execute stage has not yet fetched, the block holds the program counter and the fetch/decode register for one cycle. In that same cycle it empties the control word that decode passes on, which creates a single bubble. After the bubble, the loaded value reaches the waiting instruction through the ordinary write-back forwarding path.

The unit holds no state; every output is a combinational function of the current inputs. It also picks the destination specifier for the instruction in execute. The pipeline latches this specifier into the next stage, and the unit uses it for its own load-use comparison.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: A load-use stall is raised when `ex_mem_read` is 1 and `ex_dst` equals `id_rs` or `id_rt`. With `ex_mem_read` at 0 no stall is raised, whatever the specifiers.
- R2: During a stall, `id_ctrl_zero` is 1 while `pc_we` and `ifid_we` are 0. Outside a stall, `id_ctrl_zero` is 0 while `pc_we` and `ifid_we` are 1.
- R3: `ex_dst` equals `ex_rd` when `ex_reg_dst` is 1 and `ex_rt` when it is 0. The load-use comparison of R1 uses this chosen value.
- R4: A select is 2'b10, taking the memory-stage result, when `mem_reg_write` is 1, `mem_dst` is nonzero and `mem_dst` equals that operand's source (`ex_rs` for A, `ex_rt` for B).
- R5: A select is 2'b01, taking the write-back value, when `wb_reg_write` is 1, `wb_dst` is nonzero and `wb_dst` equals the operand's source, provided R4 does not apply to that operand.
- R6: When the memory and write-back stages both match the same operand, the select is 2'b10.
- R7: Register 0 is never forwarded. A producer whose destination is 0 leaves the select at 2'b00.
- R8: A producer whose register-write bit is 0 is never forwarded from. With no valid match, a select is 2'b00, the register-file value. The code 2'b11 never appears.
- R9: `fwd_a` and `fwd_b` are decided independently. Both may forward in the same cycle, each from its own stage.
- R10: A stall and forwarding may be active together. The forwarding selects for the instruction in execute are unaffected by the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | First source specifier of the instruction in decode |
| id_rt | input | REG_W | Second source specifier of the instruction in decode |
| ex_rs | input | REG_W | First source specifier of the instruction in execute |
| ex_rt | input | REG_W | Second source specifier of the instruction in execute |
| ex_rd | input | REG_W | Register-form destination specifier of the instruction in execute |
| ex_reg_dst | input | 1 | 1 picks `ex_rd` as destination, 0 picks `ex_rt` |
| ex_mem_read | input | 1 | The instruction in execute is a load |
| mem_reg_write | input | 1 | The instruction in memory stage writes a register |
| mem_dst | input | REG_W | Destination of the instruction in memory stage |
| wb_reg_write | input | 1 | The instruction in write-back writes a register |
| wb_dst | input | REG_W | Destination of the instruction in write-back |
| fwd_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| id_ctrl_zero | output | 1 | Force the control word entering execute to zero |
| ex_dst | output | REG_W | Chosen destination of the instruction in execute |

## Verification
Two functions can be active in the same cycle. The first is the load-use stall, which watches the decode and execute stages. The second is operand forwarding, which watches execute against memory and write-back. The bench provokes both at once by placing a load in execute whose destination a decode source needs, while the execute instruction's own sources match destinations in the later stages. It then checks that the stall outputs and both selects each take their expected values with no interference. Random vectors drawn from a small register range make such overlaps, and double matches on one operand, frequent.

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_reg_dst,
  input  logic             ex_mem_read,
  input  logic             mem_reg_write,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_reg_write,
  input  logic [REG_W-1:0] wb_dst,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             id_ctrl_zero,
  output logic [REG_W-1:0] ex_dst
);
  localparam logic [1:0]       SEL_RF   = 2'b00;
  localparam logic [1:0]       SEL_MEM  = 2'b10;
  localparam logic [1:0]       SEL_WB   = 2'b01;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic             load_use;
  logic             mem_live;
  logic             wb_live;
  logic [REG_W-1:0] src [2];
  logic [1:0]       sel [2];

  assign ex_dst   = ex_reg_dst ? ex_rd : ex_rt;
  assign load_use = ex_mem_read && ((ex_dst == id_rs) || (ex_dst == id_rt));

  assign pc_we        = !load_use;
  assign ifid_we      = !load_use;
  assign id_ctrl_zero = load_use;

  assign mem_live = mem_reg_write && (mem_dst != ZERO_REG);
  assign wb_live  = wb_reg_write  && (wb_dst  != ZERO_REG);

  assign src[0] = ex_rs;
  assign src[1] = ex_rt;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    always_comb begin
      if (mem_live && (mem_dst == src[i]))
        sel[i] = SEL_MEM;
      else if (wb_live && (wb_dst == src[i]))
        sel[i] = SEL_WB;
      else
        sel[i] = SEL_RF;
    end
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];
endmodule

// File: rtl/hazard_fwd_ctrl_chk.sv
module hazard_fwd_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] id_rs,
  input logic [REG_W-1:0] id_rt,
  input logic [REG_W-1:0] ex_rs,
  input logic [REG_W-1:0] ex_rt,
  input logic             ex_mem_read,
  input logic             mem_reg_write,
  input logic [REG_W-1:0] mem_dst,
  input logic             wb_reg_write,
  input logic [REG_W-1:0] wb_dst,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             id_ctrl_zero,
  input logic [REG_W-1:0] ex_dst
);
  always_comb begin
    AST_STALL_FREEZE: assert (id_ctrl_zero == !pc_we && id_ctrl_zero == !ifid_we); // R2
    AST_NO_STALL_WO_LOAD: assert (ex_mem_read || !id_ctrl_zero); // R1
    AST_STALL_NEEDS_MATCH: assert (!id_ctrl_zero || ex_dst == id_rs || ex_dst == id_rt); // R1
    AST_SEL_LEGAL: assert (fwd_a != 2'b11 && fwd_b != 2'b11); // R8
    AST_NO_R0_FWD: assert ((fwd_a == 2'b00 || ex_rs != '0) && (fwd_b == 2'b00 || ex_rt != '0)); // R7
    AST_MEM_WINS: assert (!(mem_reg_write && mem_dst != '0 && mem_dst == ex_rs) || fwd_a == 2'b10); // R6
    AST_WB_VALID: assert (fwd_b != 2'b01 || (wb_reg_write && wb_dst == ex_rt)); // R5
  end
endmodule

bind hazard_fwd_ctrl hazard_fwd_ctrl_chk #(.REG_W(REG_W)) chk_i (
  .id_rs(id_rs), .id_rt(id_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
  .ex_mem_read(ex_mem_read), .mem_reg_write(mem_reg_write), .mem_dst(mem_dst),
  .wb_reg_write(wb_reg_write), .wb_dst(wb_dst), .fwd_a(fwd_a), .fwd_b(fwd_b),
  .pc_we(pc_we), .ifid_we(ifid_we), .id_ctrl_zero(id_ctrl_zero), .ex_dst(ex_dst)
);

// File: tb/hazard_fwd_ctrl_test.sv
module hazard_fwd_ctrl_test;
  localparam int REG_W = 5;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 5000;

  typedef struct packed {
    logic [REG_W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd;
    logic             ex_reg_dst, ex_mem_read, mem_reg_write;
    logic [REG_W-1:0] mem_dst;
    logic             wb_reg_write;
    logic [REG_W-1:0] wb_dst;
  } vec_t;

  typedef struct packed {
    logic [1:0]       fa, fb;
    logic             pcw, ifw, cz;
    logic [REG_W-1:0] dst;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  vec_t v = '0;
  logic [1:0] fwd_a, fwd_b;
  logic pc_we, ifid_we, id_ctrl_zero;
  logic [REG_W-1:0] ex_dst;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0, cyc = 0;
  logic done = 0;

  hazard_fwd_ctrl #(.REG_W(REG_W)) uut (
    .id_rs(v.id_rs), .id_rt(v.id_rt), .ex_rs(v.ex_rs), .ex_rt(v.ex_rt),
    .ex_rd(v.ex_rd), .ex_reg_dst(v.ex_reg_dst), .ex_mem_read(v.ex_mem_read),
    .mem_reg_write(v.mem_reg_write), .mem_dst(v.mem_dst),
    .wb_reg_write(v.wb_reg_write), .wb_dst(v.wb_dst),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we),
    .id_ctrl_zero(id_ctrl_zero), .ex_dst(ex_dst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] pick(input vec_t x, input logic [REG_W-1:0] s);
    if (x.mem_reg_write && x.mem_dst != 0 && x.mem_dst == s) return 2'b10;
    if (x.wb_reg_write && x.wb_dst != 0 && x.wb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic exp_t model(input vec_t x);
    exp_t e;
    logic stall;
    e.dst = x.ex_reg_dst ? x.ex_rd : x.ex_rt;
    stall = x.ex_mem_read && (e.dst == x.id_rs || e.dst == x.id_rt);
    e.cz  = stall;
    e.pcw = !stall;
    e.ifw = !stall;
    e.fa  = pick(x, x.ex_rs);
    e.fb  = pick(x, x.ex_rt);
    return e;
  endfunction

  task automatic drive(input vec_t x, input string tag);
    @(posedge clk);
    v = x;
    exp_q.push_back(model(x));
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{fa: fwd_a, fb: fwd_b, pcw: pc_we, ifw: ifid_we, cz: id_ctrl_zero, dst: ex_dst};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual fa=%b fb=%b pcw=%b ifw=%b cz=%b dst=%0d expected fa=%b fb=%b pcw=%b ifw=%b cz=%b dst=%0d",
                   t, a.fa, a.fb, a.pcw, a.ifw, a.cz, a.dst, e.fa, e.fb, e.pcw, e.ifw, e.cz, e.dst);
        end
      end
    end
  end

  initial begin : watchdog
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    vec_t x;
    repeat (2) @(posedge clk);
    rst = 0;
    x = '0; drive(x, "R2 idle after reset");
    x = '0; x.ex_rs = 3; x.mem_reg_write = 1; x.mem_dst = 3; drive(x, "R4 mem to A");
    x = '0; x.ex_rt = 4; x.wb_reg_write = 1; x.wb_dst = 4; drive(x, "R5 wb to B");
    x = '0; x.ex_rs = 5; x.mem_reg_write = 1; x.mem_dst = 5; x.wb_reg_write = 1; x.wb_dst = 5;
    drive(x, "R6 mem beats wb");
    x = '0; x.mem_reg_write = 1; x.wb_reg_write = 1; drive(x, "R7 r0 not forwarded");
    x = '0; x.ex_rs = 3; x.ex_rt = 3; x.mem_dst = 3; x.wb_dst = 3; drive(x, "R8 write bit off");
    x = '0; x.ex_rs = 2; x.ex_rt = 4; x.mem_reg_write = 1; x.mem_dst = 2; x.wb_reg_write = 1; x.wb_dst = 4;
    drive(x, "R9 both operands");
    x = '0; x.ex_mem_read = 1; x.ex_rt = 7; x.id_rs = 7; x.id_rt = 1; drive(x, "R1 stall on rs");
    x = '0; x.ex_mem_read = 1; x.ex_rt = 6; x.id_rs = 1; x.id_rt = 6; drive(x, "R1 stall on rt");
    x = '0; x.ex_mem_read = 1; x.ex_reg_dst = 1; x.ex_rd = 9; x.ex_rt = 7; x.id_rs = 7; x.id_rt = 7;
    drive(x, "R3 rd chosen, no stall");
    x = '0; x.ex_mem_read = 1; x.ex_reg_dst = 1; x.ex_rd = 9; x.ex_rt = 7; x.id_rt = 9;
    drive(x, "R3 rd chosen, stall");
    x = '0; x.ex_rt = 7; x.id_rs = 7; drive(x, "R1 no load no stall");
    x = '0; x.ex_mem_read = 1; x.ex_rs = 2; x.ex_rt = 8; x.id_rs = 8;
    x.mem_reg_write = 1; x.mem_dst = 2; x.wb_reg_write = 1; x.wb_dst = 8;
    drive(x, "R10 stall with forwarding");
    x = '0; x.ex_rt = 4; x.wb_reg_write = 1; x.wb_dst = 4; x.mem_reg_write = 1; x.mem_dst = 6;
    drive(x, "R5 wb when mem differs");
    for (int i = 0; i < 300; i++) begin
      x = '0;
      x.id_rs = REG_W'($urandom_range(0, 3));
      x.id_rt = REG_W'($urandom_range(0, 3));
      x.ex_rs = REG_W'($urandom_range(0, 3));
      x.ex_rt = REG_W'($urandom_range(0, 3));
      x.ex_rd = REG_W'($urandom_range(0, 3));
      x.ex_reg_dst = 1'($urandom);
      x.ex_mem_read = 1'($urandom);
      x.mem_reg_write = 1'($urandom);
      x.mem_dst = REG_W'($urandom_range(0, 3));
      x.wb_reg_write = 1'($urandom);
      x.wb_dst = REG_W'($urandom_range(0, 3));
      drive(x, "R9 R10 random mix");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule